// File: doc/BRIEF.md
# Eight-bit timer/counter with two compare outputs

The block is an 8-bit up-counter that advances on a selectable prescaled tick and is compared against two independent compare channels, A and B. A small register port gives software access to the count, both compare values, a control byte (operating mode and prescaler), an interrupt-enable mask and a flag register. Three event flags exist: overflow, compare-A match and compare-B match. Each flag drives a level interrupt request when its enable bit is set. A flag clears on an interrupt-acknowledge pulse, or when software writes 1 to its bit.

There are three operating modes. Free-running mode counts up and wraps. Clear-on-match mode restarts the count after compare A, so that compare A sets the period, and each channel toggles its pin on a match. Fast PWM mode drives each pin high at the start of every period and low on its match. Compare writes land in a holding register. In PWM mode that value reaches the comparator only at the end of a period, so a period never sees a half-updated threshold.

Top module: `tmr8_pwm_timer`

## Requirements
- R1: After reset every readable register (addresses 0 count, 1 compare A, 2 compare B, 3 control, 4 enable, 5 flags, 6-7 read 0) reads 0, and both pins and all interrupt requests are low.
- R2: Each tick increments the count, wrapping 0xFF to 0x00. A tick while the count is 0xFF sets flag bit 0 (overflow).
- R3: Control bits [4:2] pick the tick rate: 0 stopped, 1 every cycle, 2 every 8, 3 every 64, 4 every 256, 5 every 1024, 6 and 7 stopped. A write to the count restarts the divider, so the first increment lands N clock edges after the write edge.
- R4: A tick while the count equals the active compare value of a channel sets flag bit 1 (A) or bit 2 (B).
- R5: In clear-on-match mode (control bits [1:0] = 1), a tick at count equal to compare A returns the count to 0, giving a period of compare A + 1 ticks. Each pin toggles on its channel's match.
- R6: irq_o[i] is high exactly while flag bit i and enable bit i are both set.
- R7: A compare write is read back at once. The active value follows it one cycle later in modes 0, 1 and 3. In PWM mode it is taken only on a tick at count 0xFF.
- R8: In fast PWM mode (control bits [1:0] = 2), a pin goes high on the tick that wraps the count and goes low on its match. An active compare of 0xFF keeps the pin high. In modes 0 and 3 the pins are low.
- R9: int_ack_i[i] clears flag i on the next edge. A flag set event in the same cycle wins.
- R10: Writing the flag register clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R11: A software write to the count takes precedence over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| int_ack_i | input | 3 | Per-flag interrupt acknowledge (0 overflow, 1 A, 2 B) |
| irq_o | output | 3 | Per-flag interrupt request |
| cmp_a_o | output | 1 | Channel A waveform pin |
| cmp_b_o | output | 1 | Channel B waveform pin |

## Verification
The bench uses the default parameters: an 8-bit count and prescaler taps at 3, 6, 8 and 10 divider bits. With a 256-step count, full wraps, PWM period boundaries and a deferred compare reload fit into short directed runs. The divide-by-8 and divide-by-64 taps are timed cycle by cycle. The divide-by-256 and divide-by-1024 taps are reached only through the random phase, which a cycle model tracks.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CTC  = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  localparam int NUM_CH    = 2;
  localparam int NUM_FLAG  = NUM_CH + 1;
  localparam int CTRL_W    = 5;
  localparam int FLAG_OVF  = 0;

  localparam int ADDR_CNT  = 0;
  localparam int ADDR_CMP0 = 1;
  localparam int ADDR_CTRL = ADDR_CMP0 + NUM_CH;
  localparam int ADDR_IE   = ADDR_CTRL + 1;
  localparam int ADDR_FLAG = ADDR_IE + 1;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
  parameter int SH1 = 3,
  parameter int SH2 = 6,
  parameter int SH3 = 8,
  parameter int SH4 = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  localparam int DIV_W = SH4;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      3'd1:    tick_o = 1'b1;
      3'd2:    tick_o = &div_q[SH1-1:0];
      3'd3:    tick_o = &div_q[SH2-1:0];
      3'd4:    tick_o = &div_q[SH3-1:0];
      3'd5:    tick_o = &div_q[SH4-1:0];
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             buf_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  mode_e            mode_i,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] buf_o,
  output logic [CNT_W-1:0] act_o,
  output logic             match_o,
  output logic             pin_o
);
  logic [CNT_W-1:0] buf_q, act_q;
  logic             pin_q;

  assign match_o = tick_i && (cnt_i == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (buf_we_i) buf_q <= wdata_i;
      // PWM: reload only at period end to avoid glitches
      if (mode_i != MODE_PWM || wrap_i) act_q <= buf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else begin
      unique case (mode_i)
        MODE_CTC: if (match_o) pin_q <= ~pin_q;
        MODE_PWM: begin
          if (wrap_i)       pin_q <= 1'b1;
          else if (match_o) pin_q <= 1'b0;
        end
        default:  pin_q <= 1'b0;
      endcase
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;
  assign pin_o = pin_q;
endmodule

// File: rtl/tmr8_pwm_timer.sv
module tmr8_pwm_timer
  import tmr8_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    rdata_o,
  input  logic [NUM_FLAG-1:0] int_ack_i,
  output logic [NUM_FLAG-1:0] irq_o,
  output logic                cmp_a_o,
  output logic                cmp_b_o
);
  logic [CNT_W-1:0]    cnt_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_FLAG-1:0] ie_q, flags_q, flag_set, flag_clr;
  logic                tick, wrap, ctc_clr;
  logic                cnt_we, ctrl_we, ie_we, flag_we;
  mode_e               mode;
  logic [2:0]          sel;

  logic [NUM_CH-1:0][CNT_W-1:0] buf_v, act_v;
  logic [NUM_CH-1:0]            match, pin_v;

  assign mode = mode_e'(ctrl_q[1:0]);
  assign sel  = ctrl_q[4:2];

  assign cnt_we  = wr_en_i && (addr_i == ADDR_W'(ADDR_CNT));
  assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign ie_we   = wr_en_i && (addr_i == ADDR_W'(ADDR_IE));
  assign flag_we = wr_en_i && (addr_i == ADDR_W'(ADDR_FLAG));

  tmr8_prescale u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cnt_we),
    .sel_i     (sel),
    .tick_o    (tick)
  );

  assign wrap    = tick && (cnt_q == '1);
  assign ctc_clr = (mode == MODE_CTC) && match[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= wdata_i;
    else if (tick)   cnt_q <= ctc_clr ? '0 : cnt_q + 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    tmr8_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .buf_we_i (wr_en_i && (addr_i == ADDR_W'(ADDR_CMP0 + ch))),
      .wdata_i  (wdata_i),
      .mode_i   (mode),
      .tick_i   (tick),
      .wrap_i   (wrap),
      .cnt_i    (cnt_q),
      .buf_o    (buf_v[ch]),
      .act_o    (act_v[ch]),
      .match_o  (match[ch]),
      .pin_o    (pin_v[ch])
    );
  end

  assign flag_set = {match, wrap};
  assign flag_clr = int_ack_i | (flag_we ? wdata_i[NUM_FLAG-1:0] : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ie_q    <= '0;
      flags_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (ie_we)   ie_q   <= wdata_i[NUM_FLAG-1:0];
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (int'(addr_i))
      ADDR_CNT:      rdata_o = cnt_q;
      ADDR_CMP0:     rdata_o = buf_v[0];
      ADDR_CMP0 + 1: rdata_o = buf_v[1];
      ADDR_CTRL:     rdata_o = CNT_W'(ctrl_q);
      ADDR_IE:       rdata_o = CNT_W'(ie_q);
      ADDR_FLAG:     rdata_o = CNT_W'(flags_q);
      default:       rdata_o = '0;
    endcase
  end

  assign irq_o   = flags_q & ie_q;
  assign cmp_a_o = pin_v[0];
  assign cmp_b_o = pin_v[1];
endmodule

// File: rtl/tmr8_pwm_timer_chk.sv
module tmr8_pwm_timer_chk
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick,
  input logic                wrap,
  input logic                cnt_we,
  input logic [CNT_W-1:0]    cnt_q,
  input logic [1:0]          mode_bits,
  input logic [2:0]          sel,
  input logic [NUM_CH-1:0]   match,
  input logic [NUM_FLAG-1:0] flags_q,
  input logic [NUM_FLAG-1:0] int_ack_i,
  input logic                cmp_a_o,
  input logic                cmp_b_o
);
  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flags_q[FLAG_OVF]); // R2

  AST_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel == 3'd0 || sel > 3'd5) && !cnt_we) |=> $stable(cnt_q)); // R3

  AST_MATCH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match[0] |=> flags_q[1]); // R4

  AST_CTC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_bits == MODE_CTC && match[0] && !cnt_we) |=> (cnt_q == '0)); // R5

  AST_PWM_PERIOD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_bits == MODE_PWM && wrap) |=> (cmp_a_o && cmp_b_o)); // R8

  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ack_i[FLAG_OVF] && !wrap) |=> !flags_q[FLAG_OVF]); // R9

  AST_TICK_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_we && !(mode_bits == MODE_CTC && match[0])) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R11
endmodule

bind tmr8_pwm_timer tmr8_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick      (tick),
  .wrap      (wrap),
  .cnt_we    (cnt_we),
  .cnt_q     (cnt_q),
  .mode_bits (ctrl_q[1:0]),
  .sel       (sel),
  .match     (match),
  .flags_q   (flags_q),
  .int_ack_i (int_ack_i),
  .cmp_a_o   (cmp_a_o),
  .cmp_b_o   (cmp_b_o)
);

// File: tb/tmr8_pwm_timer_tb.sv
`timescale 1ns/1ps
module tmr8_pwm_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] ack = '0;
  logic [2:0] irq;
  logic       pin_a, pin_b;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tmr8_pwm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .int_ack_i(ack), .irq_o(irq), .cmp_a_o(pin_a), .cmp_b_o(pin_b)
  );

  // ---------------- cycle model written from the requirements ----------------
  logic [7:0] m_cnt, m_ctrl, m_ie, m_fl;
  logic [9:0] m_div;
  logic [7:0] m_buf [2];
  logic [7:0] m_act [2];
  logic       m_pin [2];

  function automatic logic tick_of(input logic [2:0] s, input logic [9:0] d);
    case (s)
      3'd1: return 1'b1;
      3'd2: return d[2:0] == 3'h7;
      3'd3: return d[5:0] == 6'h3f;
      3'd4: return d[7:0] == 8'hff;
      3'd5: return d == 10'h3ff;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_buf[0];
      3'd2: return m_buf[1];
      3'd3: return m_ctrl;
      3'd4: return m_ie;
      3'd5: return m_fl;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic t, wr_cnt, wrp;
    logic [1:0] md;
    logic [1:0] mt;
    logic [2:0] clr;
    if (!rst_n) begin
      m_cnt = 0; m_ctrl = 0; m_ie = 0; m_fl = 0; m_div = 0;
      for (int i = 0; i < 2; i++) begin m_buf[i] = 0; m_act[i] = 0; m_pin[i] = 0; end
    end else begin
      md     = m_ctrl[1:0];
      t      = tick_of(m_ctrl[4:2], m_div);
      wr_cnt = wr_en && addr == 3'd0;
      wrp    = t && m_cnt == 8'hff;
      for (int i = 0; i < 2; i++) mt[i] = t && m_cnt == m_act[i];
      for (int i = 0; i < 2; i++) begin
        if (md == 2'd1) begin if (mt[i]) m_pin[i] = ~m_pin[i]; end
        else if (md == 2'd2) begin
          if (wrp) m_pin[i] = 1'b1; else if (mt[i]) m_pin[i] = 1'b0;
        end else m_pin[i] = 1'b0;
        if (md != 2'd2 || wrp) m_act[i] = m_buf[i];
        if (wr_en && addr == 3'(i + 1)) m_buf[i] = wdata;
      end
      clr  = ack | ((wr_en && addr == 3'd5) ? wdata[2:0] : 3'b000);
      m_fl = {5'b0, (m_fl[2:0] & ~clr) | {mt, wrp}};
      if (wr_cnt) m_cnt = wdata;
      else if (t) m_cnt = (md == 2'd1 && mt[0]) ? 8'h00 : m_cnt + 8'd1;
      m_div = wr_cnt ? 10'd0 : m_div + 10'd1;
      if (wr_en && addr == 3'd3) m_ctrl = {3'b0, wdata[4:0]};
      if (wr_en && addr == 3'd4) m_ie = {5'b0, wdata[2:0]};
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_71c3));
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 3'(a), 8'h00);
    check("R1 reset irq", irq, 3'b000);
    check("R1 reset pins", {pin_a, pin_b}, 2'b00);

    // R3 divide by 8
    wr(3'd3, 8'h08);
    wr(3'd0, 8'h10);
    wait_n(7); rd_chk("R3 /8 before", 3'd0, 8'h10);
    wait_n(1); rd_chk("R3 /8 step", 3'd0, 8'h11);
    // R3 divide by 64
    wr(3'd3, 8'h0C);
    wr(3'd0, 8'h20);
    wait_n(63); rd_chk("R3 /64 before", 3'd0, 8'h20);
    wait_n(1);  rd_chk("R3 /64 step", 3'd0, 8'h21);
    // R3 stopped selections
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h55);
    wait_n(20); rd_chk("R3 sel0 stopped", 3'd0, 8'h55);
    wr(3'd3, 8'h18);
    wait_n(20); rd_chk("R3 sel6 stopped", 3'd0, 8'h55);

    // R2 / R11 overflow, write precedence
    wr(3'd5, 8'h07);
    wr(3'd3, 8'h04);
    wr(3'd0, 8'hFE);
    rd_chk("R11 write beats tick", 3'd0, 8'hFE);
    wait_n(1); rd_chk("R2 count FF", 3'd0, 8'hFF);
    wait_n(1); rd_chk("R2 wrap to 0", 3'd0, 8'h00);
    rd_chk("R2 overflow flag", 3'd5, 8'h01);
    check("R6 irq masked", irq, 3'b000);

    // R6 enable gating (compare matches at 0 set A and B next edge)
    wr(3'd4, 8'h01);
    check("R6 irq ovf only", irq, 3'b001);
    wr(3'd4, 8'h07);
    check("R6 irq all", irq, 3'b111);

    // R10 write-1-to-clear
    wr(3'd5, 8'h00); rd_chk("R10 zero write keeps", 3'd5, 8'h07);
    wr(3'd5, 8'h02); rd_chk("R10 clear bit1", 3'd5, 8'h05);
    wr(3'd5, 8'h05); rd_chk("R10 clear rest", 3'd5, 8'h00);
    check("R6 irq after clear", irq, 3'b000);

    // R9 acknowledge, set wins over clear on other bits
    wr(3'd0, 8'hFF);
    wait_n(1); rd_chk("R9 ovf set", 3'd5, 8'h01);
    ack = 3'b001;
    wait_n(1); ack = 3'b110; rd_chk("R9 ack clears ovf", 3'd5, 8'h06);
    wait_n(1); ack = 3'b000; rd_chk("R9 ack clears A B", 3'd5, 8'h00);

    // R7 readback, R4 match flags
    wr(3'd1, 8'h30); rd_chk("R7 readback A", 3'd1, 8'h30);
    wr(3'd2, 8'h31); rd_chk("R7 readback B", 3'd2, 8'h31);
    wr(3'd5, 8'h07);
    wr(3'd0, 8'h2F);
    wait_n(2); rd_chk("R4 match A", 3'd5, 8'h02);
    wait_n(1); rd_chk("R4 match B", 3'd5, 8'h06);

    // R5 clear-on-match period and toggle
    wr(3'd5, 8'h07);
    wr(3'd1, 8'h03);
    wr(3'd3, 8'h05);
    check("R8 pins low in free mode", {pin_a}, 1'b0);
    wr(3'd0, 8'h00);
    wait_n(3); rd_chk("R5 reaches top", 3'd0, 8'h03);
    wait_n(1); rd_chk("R5 restart", 3'd0, 8'h00);
    check("R5 toggle high", pin_a, 1'b1);
    wait_n(4); rd_chk("R5 period", 3'd0, 8'h00);
    check("R5 toggle low", pin_a, 1'b0);

    // R7 / R8 fast PWM with deferred reload
    wr(3'd3, 8'h06);
    wr(3'd1, 8'h80);
    rd_chk("R7 PWM readback", 3'd1, 8'h80);
    wr(3'd2, 8'hFF);
    wr(3'd5, 8'h07);
    wr(3'd0, 8'h02);
    for (int k = 1; k <= 600; k++) begin
      wait_n(1);
      if (k == 2) rd_chk("R7 old compare active", 3'd5, 8'h02);
      if (k == 3) check("R8 low on match", pin_a, 1'b0);
      if (k == 254) check("R8 high at period start", {pin_a, pin_b}, 2'b11);
      if (k == 382) check("R8 high before new match", pin_a, 1'b1);
      if (k == 383) check("R7 R8 low on reloaded match", pin_a, 1'b0);
      if (k >= 254 && k % 50 == 0) check("R8 FF stays high", pin_b, 1'b1);
    end

    // random phase against the cycle model
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = int'($urandom % 16);
      wr_en = 1'b0;
      addr  = 3'($urandom % 8);
      wdata = 8'($urandom);
      case (op)
        0: begin wr_en = 1'b1; addr = 3'd0; end
        1: begin wr_en = 1'b1; addr = 3'd1; end
        2: begin wr_en = 1'b1; addr = 3'd2; end
        3: begin
          int s;
          s = int'($urandom % 10);
          wr_en = 1'b1; addr = 3'd3;
          wdata = {3'($urandom), (s < 5) ? 3'd1 : (s < 7) ? 3'd2 : 3'($urandom % 8), 2'($urandom)};
        end
        4: begin wr_en = 1'b1; addr = 3'd4; end
        5: begin wr_en = 1'b1; addr = 3'd5; end
        default: ;
      endcase
      ack = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
      #1;
      check("R1 random read", rdata, m_read(addr));
      check("R6 random irq", irq, m_fl[2:0] & m_ie[2:0]);
      check("R8 R5 random pins", {pin_a, pin_b}, {m_pin[0], m_pin[1]});
      @(negedge clk);
    end
    wr_en = 1'b0; ack = '0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule